// File: doc/BRIEF.md
# Self-Routing Omega Switch Network

This block is an N-by-N blocking interconnect made of 2x2 steering elements. Every input port offers a request made of a valid flag, a destination port index and a payload word. The fabric has log2(N) columns of N/2 elements. Before each column, the links pass through a perfect shuffle, which rotates the link index left by one bit. Each element in column k looks at one destination bit, and uses no table and no central controller. Because each element decides alone, some permutations collide inside the fabric. The block resolves each collision by fixed priority and tells each source whether its request was lost.

The steering logic is purely combinational. A parameter selects a register stage on the outputs, and that register is enabled by default. Each output port presents a valid flag, the payload that arrived there, and the index of the input it came from. A per-input blocked vector lets the surrounding logic decide whether to try again in a later cycle.

There are no states to name. The only sequential element is the output register, which moves from cleared (while `rst_n` is low) to loaded (on every rising clock edge after reset).

Top module: `omega_net`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `blocked` are all zero.
- R2: With the default `OUT_REG = 1`, outputs reflect the inputs sampled at the previous rising clock edge. A change to the inputs does not show on the outputs before that edge.
- R3: A valid input `s` with destination `d` that is not dropped appears on output port `d`, with `out_data[d]` equal to its payload and `out_src[d] = s`.
- R4: A permutation that causes no collision in any column, such as the identity or a constant XOR of the index, delivers every request and asserts no blocked bit.
- R5: Column k steers on destination bit `LG-1-k`, so the most significant bit is used first. A 0 takes the element's upper output (even link), and a 1 takes the lower output (odd link). When both requests at one element want the same output, the request on the upper (even) input link goes through.
- R6: A request that loses a collision sets `blocked[s]` at its source index and appears on no output port.
- R7: An input with `in_valid[s] = 0` never occupies an output, never causes a collision and is never flagged blocked, whatever its destination.
- R8: When several valid inputs name the same destination, exactly one of them is delivered.
- R9: In every cycle, the number of asserted `out_valid` bits plus the number of asserted `blocked` bits equals the number of valid inputs sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N | Request present, one bit per input port |
| in_dest | input | N x LG | Destination port index per input |
| in_data | input | N x W | Payload word per input |
| out_valid | output | N | Delivery present, one bit per output port |
| out_data | output | N x W | Payload delivered to each output port |
| out_src | output | N x LG | Index of the input whose payload is on each output |
| blocked | output | N | Request lost to a collision, flagged at its source index |

## Verification
The identity and XOR-shift permutations should pass through with no collision. They separate a correct shuffle and bit order from a wiring mistake that scrambles the ports. Sending every input to one destination forces a collision in every column, which exercises the priority rule and the blocked flags. Single directed pairs that meet in the first column show which side wins. Inputs that carry colliding destinations but no valid flag must not disturb anything. Thousands of random mixes of valid flags and destinations are then compared every clock against a behavioural path-tracing model, to cover collisions that first appear in the middle and last columns.

// File: rtl/omega_pkg.sv
package omega_pkg;

    // Perfect shuffle: rotate an lg-bit link index left by one bit.
    function automatic int shuffle_idx(input int idx, input int lg);
        int mask;
        mask = (1 << lg) - 1;
        return ((idx << 1) & mask) | ((idx >> (lg - 1)) & 1);
    endfunction

endpackage

// File: rtl/omega_element.sv
module omega_element #(
    parameter int W   = 8,
    parameter int LG  = 3,
    parameter int BIT = 0
) (
    input  logic          up_v,
    input  logic [LG-1:0] up_dest,
    input  logic [LG-1:0] up_src,
    input  logic [W-1:0]  up_data,
    input  logic          lo_v,
    input  logic [LG-1:0] lo_dest,
    input  logic [LG-1:0] lo_src,
    input  logic [W-1:0]  lo_data,
    output logic          o0_v,
    output logic [LG-1:0] o0_dest,
    output logic [LG-1:0] o0_src,
    output logic [W-1:0]  o0_data,
    output logic          o1_v,
    output logic [LG-1:0] o1_dest,
    output logic [LG-1:0] o1_src,
    output logic [W-1:0]  o1_data,
    output logic          drop_v,
    output logic [LG-1:0] drop_src
);

    logic up_sel, lo_sel, clash, lo_go, up_to0, up_to1;

    always_comb begin
        up_sel = up_dest[BIT];
        lo_sel = lo_dest[BIT];
        clash  = up_v && lo_v && (up_sel == lo_sel);
        lo_go  = lo_v && !clash;
        up_to0 = up_v && !up_sel;
        up_to1 = up_v && up_sel;

        o0_v    = up_to0 || (lo_go && !lo_sel);
        o0_dest = up_to0 ? up_dest : lo_dest;
        o0_src  = up_to0 ? up_src  : lo_src;
        o0_data = up_to0 ? up_data : lo_data;

        o1_v    = up_to1 || (lo_go && lo_sel);
        o1_dest = up_to1 ? up_dest : lo_dest;
        o1_src  = up_to1 ? up_src  : lo_src;
        o1_data = up_to1 ? up_data : lo_data;

        drop_v   = clash;
        drop_src = lo_src;
    end

    always_comb begin
        AST_ELEM_CONSERVE: assert (int'(o0_v) + int'(o1_v) + int'(drop_v)
                                   == int'(up_v) + int'(lo_v)); // R9
        if (drop_v) begin
            AST_UPPER_WINS: assert ((up_sel ? o1_v : o0_v)
                                    && ((up_sel ? o1_src : o0_src) == up_src)); // R5
        end
    end

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
    parameter int N     = 8,
    parameter int W     = 8,
    parameter int LG    = 3,
    parameter int STAGE = 0
) (
    input  logic [N-1:0]             in_v,
    input  logic [N-1:0][LG-1:0]     in_dest,
    input  logic [N-1:0][LG-1:0]     in_src,
    input  logic [N-1:0][W-1:0]      in_data,
    output logic [N-1:0]             out_v,
    output logic [N-1:0][LG-1:0]     out_dest,
    output logic [N-1:0][LG-1:0]     out_src,
    output logic [N-1:0][W-1:0]      out_data,
    output logic [N/2-1:0]           drop_v,
    output logic [N/2-1:0][LG-1:0]   drop_src
);

    localparam int HALF    = N / 2;
    localparam int STEER_B = LG - 1 - STAGE;

    logic [N-1:0]         sh_v;
    logic [N-1:0][LG-1:0] sh_dest;
    logic [N-1:0][LG-1:0] sh_src;
    logic [N-1:0][W-1:0]  sh_data;

    for (genvar i = 0; i < N; i++) begin : g_shuffle
        localparam int P = omega_pkg::shuffle_idx(i, LG);
        assign sh_v[P]    = in_v[i];
        assign sh_dest[P] = in_dest[i];
        assign sh_src[P]  = in_src[i];
        assign sh_data[P] = in_data[i];
    end

    for (genvar j = 0; j < HALF; j++) begin : g_elem
        omega_element #(
            .W   (W),
            .LG  (LG),
            .BIT (STEER_B)
        ) u_elem (
            .up_v     (sh_v[2*j]),
            .up_dest  (sh_dest[2*j]),
            .up_src   (sh_src[2*j]),
            .up_data  (sh_data[2*j]),
            .lo_v     (sh_v[2*j+1]),
            .lo_dest  (sh_dest[2*j+1]),
            .lo_src   (sh_src[2*j+1]),
            .lo_data  (sh_data[2*j+1]),
            .o0_v     (out_v[2*j]),
            .o0_dest  (out_dest[2*j]),
            .o0_src   (out_src[2*j]),
            .o0_data  (out_data[2*j]),
            .o1_v     (out_v[2*j+1]),
            .o1_dest  (out_dest[2*j+1]),
            .o1_src   (out_src[2*j+1]),
            .o1_data  (out_data[2*j+1]),
            .drop_v   (drop_v[j]),
            .drop_src (drop_src[j])
        );
    end

endmodule

// File: rtl/omega_net.sv
module omega_net #(
    parameter  int N       = 8,
    parameter  int W       = 8,
    parameter  bit OUT_REG = 1'b1,
    localparam int LG      = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         in_valid,
    input  logic [N-1:0][LG-1:0] in_dest,
    input  logic [N-1:0][W-1:0]  in_data,
    output logic [N-1:0]         out_valid,
    output logic [N-1:0][W-1:0]  out_data,
    output logic [N-1:0][LG-1:0] out_src,
    output logic [N-1:0]         blocked
);

    localparam int HALF = N / 2;

    logic [LG:0][N-1:0]              lnk_v;
    logic [LG:0][N-1:0][LG-1:0]      lnk_dest;
    logic [LG:0][N-1:0][LG-1:0]      lnk_src;
    logic [LG:0][N-1:0][W-1:0]       lnk_data;
    logic [LG-1:0][HALF-1:0]         drp_v;
    logic [LG-1:0][HALF-1:0][LG-1:0] drp_src;
    logic [N-1:0]                    blk_c;

    for (genvar i = 0; i < N; i++) begin : g_src
        assign lnk_v[0][i]    = in_valid[i];
        assign lnk_dest[0][i] = in_dest[i];
        assign lnk_src[0][i]  = LG'(i);
        assign lnk_data[0][i] = in_data[i];
    end

    for (genvar s = 0; s < LG; s++) begin : g_col
        omega_stage #(
            .N     (N),
            .W     (W),
            .LG    (LG),
            .STAGE (s)
        ) u_stage (
            .in_v     (lnk_v[s]),
            .in_dest  (lnk_dest[s]),
            .in_src   (lnk_src[s]),
            .in_data  (lnk_data[s]),
            .out_v    (lnk_v[s+1]),
            .out_dest (lnk_dest[s+1]),
            .out_src  (lnk_src[s+1]),
            .out_data (lnk_data[s+1]),
            .drop_v   (drp_v[s]),
            .drop_src (drp_src[s])
        );
    end

    always_comb begin
        blk_c = '0;
        for (int s = 0; s < LG; s++) begin
            for (int j = 0; j < HALF; j++) begin
                if (drp_v[s][j]) blk_c[drp_src[s][j]] = 1'b1;
            end
        end
    end

    for (genvar d = 0; d < N; d++) begin : g_land
        always_comb begin
            if (lnk_v[LG][d]) begin
                AST_LANDS_ON_DEST: assert (lnk_dest[LG][d] == LG'(d)); // R3
            end
        end
    end

    if (OUT_REG) begin : g_oreg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_valid <= '0;
                out_data  <= '0;
                out_src   <= '0;
                blocked   <= '0;
            end else begin
                out_valid <= lnk_v[LG];
                out_data  <= lnk_data[LG];
                out_src   <= lnk_src[LG];
                blocked   <= blk_c;
            end
        end

        AST_COUNT_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (($countones(out_valid) + $countones(blocked))
                      == $countones($past(in_valid)))); // R9
        AST_BLOCK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((blocked & ~$past(in_valid)) == '0)); // R7
        AST_RESET_CLEAR: assert property (@(posedge clk)
            !rst_n |-> (out_valid == '0 && blocked == '0)); // R1
    end else begin : g_comb
        assign out_valid = lnk_v[LG];
        assign out_data  = lnk_data[LG];
        assign out_src   = lnk_src[LG];
        assign blocked   = blk_c;
    end

endmodule

// File: tb/test_omega_net.sv
module test_omega_net;

    localparam int N  = 8;
    localparam int W  = 8;
    localparam int LG = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N-1:0]         in_valid = '0;
    logic [N-1:0][LG-1:0] in_dest = '0;
    logic [N-1:0][W-1:0]  in_data = '0;
    logic [N-1:0]         out_valid;
    logic [N-1:0][W-1:0]  out_data;
    logic [N-1:0][LG-1:0] out_src;
    logic [N-1:0]         blocked;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [N-1:0]         exp_ov;
    logic [N-1:0][W-1:0]  exp_od;
    logic [N-1:0][LG-1:0] exp_os;
    logic [N-1:0]         exp_blk;

    always #10 clk = ~clk;

    omega_net #(.N(N), .W(W)) i_omega_net (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_dest   (in_dest),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_src   (out_src),
        .blocked   (blocked)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural path trace: follow each request link by link.
    task automatic model();
        int  pos[N];
        int  p[N];
        bit  alive[N];
        bit  b[N];
        bit  drop[N];
        exp_ov = '0; exp_od = '0; exp_os = '0; exp_blk = '0;
        for (int s = 0; s < N; s++) begin
            alive[s] = in_valid[s];
            pos[s] = s;
        end
        for (int k = 0; k < LG; k++) begin
            for (int s = 0; s < N; s++) begin
                p[s] = ((pos[s] * 2) % N) + (pos[s] / (N / 2));
                b[s] = in_dest[s][LG-1-k];
                drop[s] = 1'b0;
            end
            for (int s = 0; s < N; s++) begin
                if (alive[s] && (p[s] % 2 == 1)) begin
                    for (int t = 0; t < N; t++) begin
                        if (alive[t] && p[t] == p[s] - 1 && b[t] == b[s]) drop[s] = 1'b1;
                    end
                end
            end
            for (int s = 0; s < N; s++) begin
                if (drop[s]) begin
                    alive[s] = 1'b0;
                    exp_blk[s] = 1'b1;
                end else if (alive[s]) begin
                    pos[s] = (p[s] / 2) * 2 + int'(b[s]);
                end
            end
        end
        for (int s = 0; s < N; s++) begin
            if (alive[s]) begin
                exp_ov[pos[s]] = 1'b1;
                exp_od[pos[s]] = in_data[s];
                exp_os[pos[s]] = LG'(s);
            end
        end
    endtask

    task automatic compare();
        check(out_valid == exp_ov, "R3 out_valid", int'(out_valid), int'(exp_ov));
        check(blocked == exp_blk, "R6 blocked", int'(blocked), int'(exp_blk));
        check($countones(out_valid) + $countones(blocked) == $countones(in_valid),
              "R9 count", $countones(out_valid) + $countones(blocked), $countones(in_valid));
        for (int d = 0; d < N; d++) begin
            if (exp_ov[d]) begin
                check(out_data[d] == exp_od[d], "R3 data", int'(out_data[d]), int'(exp_od[d]));
                check(out_src[d] == exp_os[d], "R3 src", int'(out_src[d]), int'(exp_os[d]));
            end
        end
    endtask

    // Called at a negedge: drive, predict, then compare one edge later.
    task automatic apply(input logic [N-1:0] v, input logic [N-1:0][LG-1:0] dst,
                         input logic [N-1:0][W-1:0] dat);
        in_valid = v; in_dest = dst; in_data = dat;
        model();
        @(negedge clk);
        compare();
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=%0d expected<100000", cyc);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [N-1:0][LG-1:0] dst;
        logic [N-1:0][W-1:0]  dat;

        // R1: reset holds outputs clear even with requests present
        in_valid = '1;
        for (int i = 0; i < N; i++) begin
            in_dest[i] = LG'(i);
            in_data[i] = W'(8'h40 + i);
        end
        repeat (3) @(negedge clk);
        check(out_valid == '0, "R1 out_valid in reset", int'(out_valid), 0);
        check(blocked == '0, "R1 blocked in reset", int'(blocked), 0);
        rst_n = 1'b1;
        in_valid = '0;
        @(negedge clk);

        // R2: identity driven, nothing visible before the edge
        for (int i = 0; i < N; i++) begin
            dst[i] = LG'(i);
            dat[i] = W'(8'hA0 + i);
        end
        in_valid = '1; in_dest = dst; in_data = dat;
        model();
        #1;
        check(out_valid == '0, "R2 before edge", int'(out_valid), 0);
        @(negedge clk);
        compare();
        // R4: identity fully delivered
        check(out_valid == '1 && blocked == '0, "R4 identity", int'(out_valid), 8'hFF);

        // R4: XOR permutation
        for (int i = 0; i < N; i++) dst[i] = LG'(i ^ 5);
        apply('1, dst, dat);
        check(out_valid == '1 && blocked == '0, "R4 xor perm", int'(blocked), 0);

        // R5 and R6: inputs 0 and 4 meet at element 0 of column 0, both to port 0
        dst = '0;
        dat = '0; dat[0] = 8'h11; dat[4] = 8'h44;
        apply(8'b0001_0001, dst, dat);
        check(out_valid == 8'b0000_0001 && out_src[0] == 3'd0, "R5 upper wins",
              int'(out_src[0]), 0);
        check(blocked == 8'b0001_0000, "R6 lower flagged", int'(blocked), 8'h10);

        // R8: everyone to port 3
        for (int i = 0; i < N; i++) begin
            dst[i] = 3'd3;
            dat[i] = W'(i * 3);
        end
        apply('1, dst, dat);
        check($countones(out_valid) == 1 && out_valid[3], "R8 single winner",
              int'(out_valid), 8'h08);

        // R7: colliding destinations but no valid flags
        apply('0, dst, dat);
        check(out_valid == '0 && blocked == '0, "R7 invalid idle", int'(blocked), 0);
        // R7: only input 4 valid; invalid input 0 with same destination must not win
        apply(8'b0001_0000, dst, dat);
        check(out_valid == 8'b0000_1000 && out_src[3] == 3'd4 && blocked == '0,
              "R7 invalid no clash", int'(out_src[3]), 4);

        // Random mixes, compared every clock
        for (int r = 0; r < 3000; r++) begin
            logic [N-1:0] v;
            v = N'($urandom);
            for (int i = 0; i < N; i++) begin
                dst[i] = LG'($urandom);
                dat[i] = W'($urandom);
            end
            apply(v, dst, dat);
        end

        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        #1;
        check(out_valid == '0 && blocked == '0, "R1 async clear", int'(out_valid), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule